// File: doc/BRIEF.md
# Latency-Measuring Asynchronous FIFO

This block moves data words from a write clock domain into an independent read clock domain through a small dual-port buffer. Each side keeps its own pointer. The pointers cross between domains as Gray code through two-flop synchronisers. The write side flags when the buffer is full, and the read side flags when it is empty. The write side also publishes the number of words currently held, expressed in its own clock domain, so a latency budget can be computed from it.

A third clock, the calculation clock, measures how the two pointers move relative to each other. On each of its edges it samples one bit: the parity of the difference between the synchronised write and read pointers. It adds that bit to an accumulator. After a programmable number of samples N, the sum is published, a one-cycle strobe marks the update, and the accumulator starts again from zero. The calculation clock can be the write clock itself. If it is held low, no measurement is made. N is a quasi-static input and is synchronised into the calculation domain.

Top module: `lat_meas_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port. The word at the head of the buffer is visible on the read data port whenever empty is low.
- R2: Full rises in the write domain once 2^AW words are held. A write request while full is dropped and stores nothing.
- R3: Empty is high in the read domain when no word is held. A read request while empty moves no pointer, so the next word written is the next word read.
- R4: The fill level output, in the write domain, equals words accepted minus words read once the read pointer has crossed over. It never exceeds 2^AW.
- R5: The published phase sum equals the number of samples in the window in which the occupancy parity was odd. With an odd, steady occupancy it equals N. With an even, steady occupancy it is 0.
- R6: For N of 2 or more, the valid strobe is high for exactly one calculation-clock cycle every N cycles, and the published sum changes only in a strobe cycle.
- R7: With N equal to 0, no measurement runs, the strobe stays low and the published sum holds.
- R8: While the calculation clock is held low, the strobe stays low and the sum holds. Measurement resumes when the clock returns.
- R9: During reset, empty is high, full is low, the fill level is 0, the phase sum is 0 and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| full | output | 1 | Buffer full, write domain |
| fill_level | output | AW+1 | Words held, write domain |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request (pops the head word) |
| rd_data | output | DW | Head word of the buffer |
| empty | output | 1 | Buffer empty, read domain |
| calc_clk | input | 1 | Measurement clock (may be the write clock or tied low) |
| calc_rst | input | 1 | Synchronous active-high reset, measurement domain |
| samp_n | input | SW | Samples per measurement window, N |
| phase_acc | output | SW | Published phase sum |
| acc_valid | output | 1 | One-cycle strobe on each new phase sum |

## Verification
Some properties are checked on every clock by the assertions. The Gray pointers never change by more than one bit per edge. Requests on a full or empty buffer leave the pointers unchanged. The fill level stays within the buffer depth. The published sum moves only with its strobe, the strobe is a single-cycle pulse for N of 2 or more, and it stays low when N is 0. Other behaviour needs the bench scenarios. Data ordering across wrap-around, the exact sums for odd and even steady occupancies, the strobe period after N changes, and the absence of measurement while the calculation clock is stopped all depend on whole sequences and are checked there.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
    // Default geometry shared by the block and its bench
    localparam int PMF_DW_DEF = 32;
    localparam int PMF_AW_DEF = 4;
    localparam int PMF_SW_DEF = 16;

    // Measurement window state, decided each calculation-clock cycle
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,   // N is zero: nothing measured
        WIN_ACCUM = 2'd1,   // inside a window, add the sample
        WIN_CLOSE = 2'd2    // last sample of a window: publish
    } win_e;
endpackage

// File: rtl/pmf_sync.sv
module pmf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pmf_wr_ctrl.sv
module pmf_wr_ctrl #(
    parameter  int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rd_gray_s,
    output logic [AW-1:0] wr_addr,
    output logic          wr_do,
    output logic [PW-1:0] wr_gray,
    output logic          full,
    output logic [PW-1:0] level
);
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wr_bin, wr_bin_nxt, rd_bin_s;

    // Gray to binary for the synchronised read pointer
    for (genvar i = 0; i < PW; i++) begin : g_rd_bin
        assign rd_bin_s[i] = ^rd_gray_s[PW-1:i];
    end

    assign level      = wr_bin - rd_bin_s;
    assign full       = (level == PW'(DEPTH));
    assign wr_do      = wr_en & ~full;
    assign wr_bin_nxt = wr_bin + PW'(wr_do);
    assign wr_addr    = wr_bin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
        end
    end

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH));
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(wr_gray));
    // R1
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/pmf_rd_ctrl.sv
module pmf_rd_ctrl #(
    parameter  int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] wr_gray_s,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_gray,
    output logic          empty
);
    logic [PW-1:0] rd_bin, rd_bin_nxt;
    logic          rd_do;

    assign empty      = (rd_gray == wr_gray_s);
    assign rd_do      = rd_en & ~empty;
    assign rd_bin_nxt = rd_bin + PW'(rd_do);
    assign rd_addr    = rd_bin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
        end
    end

    // R3
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rd_gray));
    // R1
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/pmf_phase_acc.sv
module pmf_phase_acc
    import pmf_pkg::*;
#(
    parameter int PW = 5,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wr_gray_c,
    input  logic [PW-1:0] rd_gray_c,
    input  logic [SW-1:0] n,
    output logic [SW-1:0] res,
    output logic          vld
);
    logic [SW-1:0] cnt, acc;
    logic          flag, last;
    win_e          st;

    // Parity of the Gray XOR equals the LSB of the occupancy
    assign flag = ^(wr_gray_c ^ rd_gray_c);
    assign last = (({1'b0, cnt} + (SW+1)'(1)) >= {1'b0, n});

    always_comb begin
        if (n == '0)  st = WIN_IDLE;
        else if (last) st = WIN_CLOSE;
        else           st = WIN_ACCUM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            acc <= '0;
            res <= '0;
            vld <= 1'b0;
        end else begin
            vld <= 1'b0;
            case (st)
                WIN_IDLE: begin
                    cnt <= '0;
                    acc <= '0;
                end
                WIN_CLOSE: begin
                    res <= acc + SW'(flag);
                    vld <= 1'b1;
                    cnt <= '0;
                    acc <= '0;
                end
                default: begin
                    acc <= acc + SW'(flag);
                    cnt <= cnt + SW'(1);
                end
            endcase
        end
    end

    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> $stable(res));
    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && n > SW'(1)) |=> !vld);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (n == '0) |=> !vld);
endmodule

// File: rtl/lat_meas_fifo.sv
module lat_meas_fifo
    import pmf_pkg::*;
#(
    parameter  int DW = PMF_DW_DEF,
    parameter  int AW = PMF_AW_DEF,
    parameter  int SW = PMF_SW_DEF,
    localparam int PW = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic [PW-1:0] fill_level,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    input  logic          calc_clk,
    input  logic          calc_rst,
    input  logic [SW-1:0] samp_n,
    output logic [SW-1:0] phase_acc,
    output logic          acc_valid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_addr, rd_addr;
    logic          wr_do;
    logic [PW-1:0] wr_gray, rd_gray;
    logic [PW-1:0] wr_gray_r, rd_gray_w;   // crossed into read / write
    logic [PW-1:0] wr_gray_c, rd_gray_c;   // crossed into calc domain
    logic [SW-1:0] samp_n_c;

    pmf_wr_ctrl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rd_gray_s(rd_gray_w),
        .wr_addr(wr_addr), .wr_do(wr_do), .wr_gray(wr_gray),
        .full(full), .level(fill_level)
    );

    pmf_rd_ctrl #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wr_gray_s(wr_gray_r),
        .rd_addr(rd_addr), .rd_gray(rd_gray), .empty(empty)
    );

    pmf_sync #(.W(PW)) u_sync_w2r (.clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_r));
    pmf_sync #(.W(PW)) u_sync_r2w (.clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_w));
    pmf_sync #(.W(PW)) u_sync_w2c (.clk(calc_clk), .rst(calc_rst), .d(wr_gray), .q(wr_gray_c));
    pmf_sync #(.W(PW)) u_sync_r2c (.clk(calc_clk), .rst(calc_rst), .d(rd_gray), .q(rd_gray_c));
    pmf_sync #(.W(SW)) u_sync_n   (.clk(calc_clk), .rst(calc_rst), .d(samp_n), .q(samp_n_c));

    pmf_phase_acc #(.PW(PW), .SW(SW)) u_phase (
        .clk(calc_clk), .rst(calc_rst),
        .wr_gray_c(wr_gray_c), .rd_gray_c(rd_gray_c), .n(samp_n_c),
        .res(phase_acc), .vld(acc_valid)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_do) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: tb/lat_meas_fifo_bench.sv
module lat_meas_fifo_bench;
    localparam int DW = 32, AW = 4, SW = 16, PW = AW + 1, DEPTH = 1 << AW;

    logic wr_clk = 0, rd_clk = 0, calc_raw = 0, calc_run = 1;
    logic calc_clk;
    assign calc_clk = calc_raw & calc_run;
    always #10 wr_clk   = ~wr_clk;   // 50 MHz
    always #7  rd_clk   = ~rd_clk;
    always #11 calc_raw = ~calc_raw;

    logic          wr_rst = 1, rd_rst = 1, calc_rst = 1;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic          full, empty, acc_valid;
    logic [PW-1:0] fill_level;
    logic [SW-1:0] samp_n = 16'd8, phase_acc;

    lat_meas_fifo #(.DW(DW), .AW(AW), .SW(SW)) u_lat_meas_fifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .fill_level(fill_level),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty),
        .calc_clk(calc_clk), .calc_rst(calc_rst), .samp_n(samp_n),
        .phase_acc(phase_acc), .acc_valid(acc_valid)
    );

    int total = 0, bad = 0, vcount = 0;
    bit done = 0;
    logic [DW-1:0] exp_q [$];
    event rd_ev;

    task automatic chk_eq(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Scoreboard monitor: compares the head word with the oldest expected one
    always @(rd_ev) begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk_eq("R1 read order", rd_data, e);
    end

    always @(negedge calc_clk) if (acc_valid) vcount++;

    // Driver: a write is expected to be stored only if the model has room
    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        if (exp_q.size() < DEPTH) exp_q.push_back(d);
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic pop();
        @(negedge rd_clk);
        if (exp_q.size() > 0) -> rd_ev;
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
    endtask

    task automatic wait_valid();
        int k = 0;
        do begin @(negedge calc_clk); k++; end while (!acc_valid && k < 200);
        if (k >= 200) chk_eq("R6 strobe seen", 0, 1);
    endtask

    task automatic measure(int n_exp, int acc_exp, string tag);
        int gap = 0;
        wait_valid();
        do begin @(negedge calc_clk); gap++; end while (!acc_valid && gap < 200);
        chk_eq({"R6 period ", tag}, gap, n_exp);
        chk_eq({"R5 sum ", tag}, phase_acc, acc_exp);
    endtask

    initial begin
        #1_000_000;
        chk_eq("watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int held, vsnap;
        #195;
        // R9 reset state
        chk_eq("R9 empty", empty, 1);
        chk_eq("R9 full", full, 0);
        chk_eq("R9 level", fill_level, 0);
        chk_eq("R9 phase", phase_acc, 0);
        chk_eq("R9 valid", acc_valid, 0);
        #10;
        wr_rst = 0; rd_rst = 0; calc_rst = 0;
        #100;

        measure(8, 0, "R5 empty even");

        push(32'hA001); push(32'hA002); push(32'hA003);
        #400;
        chk_eq("R4 level 3", fill_level, 3);
        chk_eq("R3 not empty", empty, 0);
        chk_eq("R2 not full", full, 0);
        measure(8, 8, "R5 odd three");

        push(32'hA004);
        #400;
        chk_eq("R4 level 4", fill_level, 4);
        measure(8, 0, "R5 even four");

        @(negedge calc_clk) samp_n = 16'd5;
        pop(); pop(); pop();
        #400;
        chk_eq("R4 level after reads", fill_level, 1);
        measure(5, 5, "R5 odd one N5");

        // R7: N of zero stops measurement
        @(negedge calc_clk) samp_n = 16'd0;
        repeat (5) @(negedge calc_clk);
        vcount = 0;
        repeat (60) @(negedge calc_raw);
        chk_eq("R7 no strobe", vcount, 0);
        chk_eq("R7 sum held", phase_acc, 5);

        @(negedge calc_clk) samp_n = 16'd8;
        measure(8, 8, "R5 restart N8");

        // R8: stopped calculation clock
        wait_valid();
        @(negedge calc_clk);
        calc_run = 0;
        held = phase_acc; vsnap = vcount;
        pop();
        #600;
        chk_eq("R8 no strobe", vcount, vsnap);
        chk_eq("R8 strobe low", acc_valid, 0);
        chk_eq("R8 sum held", phase_acc, held);
        @(negedge calc_raw) calc_run = 1;
        measure(8, 0, "R8 resumes");

        // R2: fill to the top, extra writes dropped
        for (int i = 0; i < DEPTH + 3; i++) push(32'hB000 + i);
        #400;
        chk_eq("R2 full", full, 1);
        chk_eq("R4 level full", fill_level, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop();
        #400;
        chk_eq("R2 extra writes dropped", empty, 1);
        chk_eq("R4 level drained", fill_level, 0);
        chk_eq("R2 full cleared", full, 0);

        // R3: reads on an empty buffer move nothing
        repeat (3) begin
            @(negedge rd_clk) rd_en = 1;
            @(negedge rd_clk) rd_en = 0;
        end
        #400;
        chk_eq("R3 still empty", empty, 1);
        chk_eq("R3 level zero", fill_level, 0);
        push(32'hCAFE);
        #400;
        chk_eq("R3 word arrives", empty, 0);
        pop();
        #400;
        chk_eq("R3 empty again", empty, 1);

        // R1: mixed bursts across pointer wrap
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 5; i++) push(32'hD000 + b * 16 + i);
            #400;
            for (int i = 0; i < 3; i++) pop();
            #400;
        end
        chk_eq("R4 level mixed", fill_level, 8);
        while (exp_q.size() > 0) pop();
        #400;
        chk_eq("R3 empty end", empty, 1);
        finish_run();
    end
endmodule